// File: doc/BRIEF.md
# SDRAM Bank State Tracker with Hidden Auto-Precharge

This block watches the command pins that a memory controller drives toward a four-bank SDRAM and keeps a cycle-accurate picture of every bank: idle, open (a row is active), or precharging. It decodes the command on each rising clock edge. It counts the row-active minimum, the activate-to-column delay and the precharge time from cycle-count inputs that software or a mode block can change at runtime.

The main job is to model the precharge that the device starts on its own after a read or write issued with the auto-precharge address bit set. No command on the bus marks that precharge. The tracker starts it at the later of two points: the end of the data burst, and the expiry of the row-active minimum. It then holds the bank locked for the precharge time. A per-bank legality flag and a registered violation pulse let a scheduler or a checker find illegal traffic. A registered all-banks-idle flag gates refresh.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A command is decoded only while `cs_n` is low and `cke` is high. `{ras_n,cas_n,we_n}` gives the command: 011 activate, 101 read, 100 write, 010 precharge (`a10` high means all banks), 001 refresh. Every other pattern, and any cycle with `cs_n` high or `cke` low, does nothing.
- R2: An activate in cycle A to an idle bank shows that bank active from cycle A+1. An activate to a bank that is not idle raises `violation` and is ignored.
- R3: A read or write to an idle bank raises `violation` and is ignored. So does a read or write in a cycle earlier than A+`t_rcd`.
- R4: A legal read or write with `a10` low leaves the bank active until a later command changes it.
- R5: A legal read with `a10` high in cycle R sets S = max(R+`cas_lat`+`burst_len`, A+`t_ras`). The bank shows active until cycle S-1, precharging from cycle S, and idle from cycle S+`t_rp`.
- R6: A legal write with `a10` high in cycle R behaves the same way with S = max(R+`burst_len`+1, A+`t_ras`). The extra cycle is write recovery.
- R7: From the cycle after an auto-precharge read or write until the bank is idle again, `cmd_ok` for that bank is low. Any command that targets the bank in that window raises `violation` and is ignored.
- R8: A precharge in cycle P to an open bank is legal when P ≥ A+`t_ras`. The bank then shows precharging from P+1 and idle from P+`t_rp`. An earlier precharge raises `violation` and is ignored. A precharge to an idle bank is legal and changes nothing.
- R9: A precharge with `a10` high applies to every bank. If any bank would be illegal for it, the whole command raises `violation` and no bank changes.
- R10: A refresh with every bank idle in cycle F makes all banks show precharging (recovery) from F+1 and idle from F+`t_ras`+`t_rp`. A refresh while any bank is not idle raises `violation` and is ignored.
- R11: `all_idle` in each cycle equals the AND of `bank_idle` in the previous cycle. It is 1 after reset.
- R12: After reset every bank is idle, `cmd_ok` is all ones and `violation` is 0. `violation` is a pulse in the cycle after the offending command.
- R13: The banks run independently. A command to one bank never changes the state of another, except precharge-all and refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; low turns every command into no-op |
| ba | input | BA_W (2) | Bank select |
| a10 | input | 1 | Auto-precharge on read/write, all-banks on precharge |
| cas_lat | input | CNT_W (6) | Read latency in cycles |
| burst_len | input | CNT_W (6) | Burst length in beats |
| t_ras | input | CNT_W (6) | Activate to precharge minimum, cycles |
| t_rp | input | CNT_W (6) | Precharge duration, cycles |
| t_rcd | input | CNT_W (6) | Activate to read/write minimum, cycles |
| bank_idle | output | NUM_BANKS (4) | Bank is idle |
| bank_active | output | NUM_BANKS (4) | Bank has an open row (including auto-precharge wait) |
| bank_prechg | output | NUM_BANKS (4) | Bank is precharging or recovering from refresh |
| cmd_ok | output | NUM_BANKS (4) | Bank can accept a new command |
| all_idle | output | 1 | Registered AND of bank idle states |
| violation | output | 1 | An illegal command was seen in the previous cycle |

## Verification
The internal auto-precharge point is never visible on the bus, so a wrong burst or row-active count shows at the ports only as `bank_prechg` rising one or more cycles too early or too late. It also shifts the `bank_idle` return by the same amount. The bench therefore checks the exact cycle of each edge, in cases where the burst sets the start and in cases where the row-active minimum sets it. A lock that ends too early shows as a missing `violation` pulse one cycle after a command to the locked bank. A stale state shows as a `bank_idle` mask that disagrees with the expected one in the very next cycle.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF
   } sbt_cmd_e;

   typedef enum logic [1:0] {
      BK_IDLE,
      BK_OPEN,
      BK_APWAIT,
      BK_PRECH
   } sbt_bank_e;

endpackage

// File: rtl/sbt_cmd_decode.sv
`timescale 1ns/1ps
module sbt_cmd_decode
   import sbt_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     cke,
   output sbt_cmd_e cmd_o
);

   always_comb begin
      cmd_o = CMD_NOP;
      if (!cs_n && cke) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd_o = CMD_ACT;
            3'b101:  cmd_o = CMD_RD;
            3'b100:  cmd_o = CMD_WR;
            3'b010:  cmd_o = CMD_PRE;
            3'b001:  cmd_o = CMD_REF;
            default: cmd_o = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sbt_bank.sv
`timescale 1ns/1ps
module sbt_bank
   import sbt_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int WR_REC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             rd_i,
   input  logic             wr_i,
   input  logic             ap_i,
   input  logic             pre_i,
   input  logic             ref_i,
   input  logic [CNT_W-1:0] t_ras_i,
   input  logic [CNT_W-1:0] t_rp_i,
   input  logic [CNT_W-1:0] t_rcd_i,
   input  logic [CNT_W-1:0] cas_lat_i,
   input  logic [CNT_W-1:0] burst_len_i,
   output sbt_bank_e        state_o,
   output logic             ras_ok_o,
   output logic             rcd_ok_o
);

   localparam int LW = CNT_W + 1;

   sbt_bank_e        state_q;
   logic [CNT_W-1:0] ras_q, rcd_q;
   logic [LW-1:0]    bst_q, rp_q;

   logic [LW-1:0] rd_len, wr_len, ref_len, bst_load;
   logic [LW-1:0] ras_w, rp_w, rcd_w;

   function automatic logic [LW-1:0] sat_m1(input logic [LW-1:0] x);
      return (x == '0) ? '0 : x - LW'(1);
   endfunction

   always_comb begin
      ras_w    = {1'b0, t_ras_i};
      rp_w     = {1'b0, t_rp_i};
      rcd_w    = {1'b0, t_rcd_i};
      rd_len   = {1'b0, cas_lat_i} + {1'b0, burst_len_i};
      wr_len   = {1'b0, burst_len_i} + LW'(WR_REC);
      ref_len  = sat_m1(ras_w + rp_w);
      bst_load = rd_i ? sat_m1(rd_len) : sat_m1(wr_len);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BK_IDLE;
         ras_q   <= '0;
         rcd_q   <= '0;
         bst_q   <= '0;
         rp_q    <= '0;
      end else begin
         if (ras_q != '0) ras_q <= ras_q - CNT_W'(1);
         if (rcd_q != '0) rcd_q <= rcd_q - CNT_W'(1);
         if (bst_q != '0) bst_q <= bst_q - LW'(1);
         if (rp_q  != '0) rp_q  <= rp_q  - LW'(1);
         unique case (state_q)
            BK_IDLE: begin
               if (act_i) begin
                  state_q <= BK_OPEN;
                  ras_q   <= CNT_W'(sat_m1(ras_w));
                  rcd_q   <= CNT_W'(sat_m1(rcd_w));
               end else if (ref_i) begin
                  state_q <= BK_PRECH;
                  rp_q    <= ref_len;
               end
            end
            BK_OPEN: begin
               if ((rd_i || wr_i) && ap_i) begin
                  state_q <= BK_APWAIT;
                  bst_q   <= bst_load;
               end else if (pre_i) begin
                  if (rp_w <= LW'(1)) begin
                     state_q <= BK_IDLE;
                  end else begin
                     state_q <= BK_PRECH;
                     rp_q    <= rp_w - LW'(1);
                  end
               end
            end
            BK_APWAIT: begin
               if (bst_q <= LW'(1) && ras_q <= CNT_W'(1)) begin
                  state_q <= BK_PRECH;
                  rp_q    <= rp_w;
               end
            end
            BK_PRECH: begin
               if (rp_q <= LW'(1)) state_q <= BK_IDLE;
            end
            default: state_q <= BK_IDLE;
         endcase
      end
   end

   assign state_o  = state_q;
   assign ras_ok_o = (ras_q == '0);
   assign rcd_ok_o = (rcd_q == '0);

endmodule

// File: rtl/sdram_bank_tracker.sv
`timescale 1ns/1ps
module sdram_bank_tracker
   import sbt_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int CNT_W     = 6,
   parameter int WR_REC    = 1,
   parameter int IDLE_REG  = 1,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic                 cke,
   input  logic [BA_W-1:0]      ba,
   input  logic                 a10,
   input  logic [CNT_W-1:0]     cas_lat,
   input  logic [CNT_W-1:0]     burst_len,
   input  logic [CNT_W-1:0]     t_ras,
   input  logic [CNT_W-1:0]     t_rp,
   input  logic [CNT_W-1:0]     t_rcd,
   output logic [NUM_BANKS-1:0] bank_idle,
   output logic [NUM_BANKS-1:0] bank_active,
   output logic [NUM_BANKS-1:0] bank_prechg,
   output logic [NUM_BANKS-1:0] cmd_ok,
   output logic                 all_idle,
   output logic                 violation
);

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 2..16");
   end
   if (WR_REC < 0 || WR_REC >= (1 << CNT_W)) begin : g_bad_wrrec
      $error("WR_REC must fit in CNT_W bits");
   end
   if (IDLE_REG != 0 && IDLE_REG != 1) begin : g_bad_idlereg
      $error("IDLE_REG must be 0 or 1");
   end

   sbt_cmd_e cmd;

   sbt_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cke   (cke),
      .cmd_o (cmd)
   );

   logic [NUM_BANKS-1:0] sel, ras_ok, rcd_ok;
   logic [NUM_BANKS-1:0] act_bad, rw_bad, pre_hit, pre_bad;
   logic [NUM_BANKS-1:0] act_go, rd_go, wr_go, pre_go_b;
   logic                 pre_go, ref_bad, ref_go, any_bad;
   sbt_bank_e            st [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign sel[b]       = (ba == BA_W'(b));
      assign bank_idle[b]   = (st[b] == BK_IDLE);
      assign bank_active[b] = (st[b] == BK_OPEN) || (st[b] == BK_APWAIT);
      assign bank_prechg[b] = (st[b] == BK_PRECH);
      assign cmd_ok[b]      = (st[b] == BK_IDLE) || (st[b] == BK_OPEN);

      assign act_bad[b] = (cmd == CMD_ACT) && sel[b] && (st[b] != BK_IDLE);
      assign rw_bad[b]  = ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel[b] &&
                          !((st[b] == BK_OPEN) && rcd_ok[b]);
      assign pre_hit[b] = (cmd == CMD_PRE) && (sel[b] || a10);
      assign pre_bad[b] = pre_hit[b] && (!cmd_ok[b] ||
                          ((st[b] == BK_OPEN) && !ras_ok[b]));

      assign act_go[b]   = (cmd == CMD_ACT) && sel[b] && !act_bad[b];
      assign rd_go[b]    = (cmd == CMD_RD)  && sel[b] && !rw_bad[b];
      assign wr_go[b]    = (cmd == CMD_WR)  && sel[b] && !rw_bad[b];
      assign pre_go_b[b] = pre_hit[b] && pre_go;

      sbt_bank #(
         .CNT_W  (CNT_W),
         .WR_REC (WR_REC)
      ) u_bank (
         .clk         (clk),
         .rst_n       (rst_n),
         .act_i       (act_go[b]),
         .rd_i        (rd_go[b]),
         .wr_i        (wr_go[b]),
         .ap_i        (a10),
         .pre_i       (pre_go_b[b]),
         .ref_i       (ref_go),
         .t_ras_i     (t_ras),
         .t_rp_i      (t_rp),
         .t_rcd_i     (t_rcd),
         .cas_lat_i   (cas_lat),
         .burst_len_i (burst_len),
         .state_o     (st[b]),
         .ras_ok_o    (ras_ok[b]),
         .rcd_ok_o    (rcd_ok[b])
      );
   end

   assign pre_go  = ~|pre_bad;
   assign ref_bad = (cmd == CMD_REF) && !(&bank_idle);
   assign ref_go  = (cmd == CMD_REF) && !ref_bad;
   assign any_bad = (|act_bad) || (|rw_bad) || (|pre_bad) || ref_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) violation <= 1'b0;
      else        violation <= any_bad;
   end

   if (IDLE_REG == 1) begin : g_idle_reg
      always_ff @(posedge clk) begin
         if (!rst_n) all_idle <= 1'b1;
         else        all_idle <= &bank_idle;
      end
   end else begin : g_idle_comb
      assign all_idle = &bank_idle;
   end

endmodule

// File: rtl/sbt_checker.sv
`timescale 1ns/1ps
module sbt_checker #(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2,
   parameter int IDLE_REG  = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n,
   input logic                 cke,
   input logic [BA_W-1:0]      ba,
   input logic                 a10,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic [NUM_BANKS-1:0] bank_active,
   input logic [NUM_BANKS-1:0] bank_prechg,
   input logic [NUM_BANKS-1:0] cmd_ok,
   input logic                 all_idle,
   input logic                 violation
);

   logic on, c_act, c_rd, c_wr, c_pre, c_ref;
   assign on    = !cs_n && cke;
   assign c_act = on && ({ras_n, cas_n, we_n} == 3'b011);
   assign c_rd  = on && ({ras_n, cas_n, we_n} == 3'b101);
   assign c_wr  = on && ({ras_n, cas_n, we_n} == 3'b100);
   assign c_pre = on && ({ras_n, cas_n, we_n} == 3'b010);
   assign c_ref = on && ({ras_n, cas_n, we_n} == 3'b001);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      logic hit;
      assign hit = ((c_act || c_rd || c_wr || c_pre) && ba == BA_W'(b)) ||
                   (c_pre && a10) || c_ref;

      // R7
      busy_cmd_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!cmd_ok[b] && hit) |=> violation);

      // R2
      act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (c_act && ba == BA_W'(b) && bank_idle[b]) |=> bank_active[b]);

      // R3
      rw_idle_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((c_rd || c_wr) && ba == BA_W'(b) && bank_idle[b]) |=> (violation && bank_idle[b]));

      // R8
      prech_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bank_prechg[b] |=> (bank_prechg[b] || bank_idle[b]));

      // R13
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_idle[b] && !(c_act && ba == BA_W'(b)) && !c_ref) |=> bank_idle[b]);
   end

   if (IDLE_REG == 1) begin : g_idle_chk
      // R11
      all_idle_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (all_idle == $past(&bank_idle)));
   end

endmodule

bind sdram_bank_tracker sbt_checker #(
   .NUM_BANKS (NUM_BANKS),
   .BA_W      (BA_W),
   .IDLE_REG  (IDLE_REG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .ras_n       (ras_n),
   .cas_n       (cas_n),
   .we_n        (we_n),
   .cke         (cke),
   .ba          (ba),
   .a10         (a10),
   .bank_idle   (bank_idle),
   .bank_active (bank_active),
   .bank_prechg (bank_prechg),
   .cmd_ok      (cmd_ok),
   .all_idle    (all_idle),
   .violation   (violation)
);

// File: tb/sdram_bank_tracker_tb.sv
`timescale 1ns/1ps
module sdram_bank_tracker_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
   logic [1:0] ba = '0;
   logic       a10 = 1'b0;
   logic [5:0] cas_lat = 6'd2, burst_len = 6'd4;
   logic [5:0] t_ras = 6'd6, t_rp = 6'd3, t_rcd = 6'd2;
   logic [3:0] bank_idle, bank_active, bank_prechg, cmd_ok;
   logic       all_idle, violation;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sdram_bank_tracker u_dut (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
      .we_n (we_n), .cke (cke), .ba (ba), .a10 (a10), .cas_lat (cas_lat),
      .burst_len (burst_len), .t_ras (t_ras), .t_rp (t_rp), .t_rcd (t_rcd),
      .bank_idle (bank_idle), .bank_active (bank_active), .bank_prechg (bank_prechg),
      .cmd_ok (cmd_ok), .all_idle (all_idle), .violation (violation)
   );

   // command codes used by the bench: 0 nop, 1 act, 2 rd, 3 wr, 4 pre, 5 ref
   function automatic logic [19:0] mkv(input int c, input int b, input bit ap, input bit ke,
                                       input logic [3:0] i, input logic [3:0] a,
                                       input logic [3:0] p, input bit v);
      logic [2:0] c3 = 3'(c);
      logic [1:0] b2 = 2'(b);
      return {c3, b2, ap, ke, i, a, p, v};
   endfunction

   // timing: t_ras 6, t_rp 3, t_rcd 2, cas_lat 2, burst_len 4; expected = state one cycle later
   localparam int NV = 35;
   localparam logic [19:0] VEC [NV] = '{
      mkv(1,0,0,1, 4'b1110,4'b0001,4'b0000,0),  // 0  R2 activate bank0
      mkv(2,0,0,1, 4'b1110,4'b0001,4'b0000,1),  // 1  R3 read before t_rcd
      mkv(2,0,1,1, 4'b1110,4'b0001,4'b0000,0),  // 2  R5 read + auto-precharge, start 8
      mkv(1,1,0,1, 4'b1100,4'b0011,4'b0000,0),  // 3  R13 activate bank1
      mkv(3,0,0,1, 4'b1100,4'b0011,4'b0000,1),  // 4  R7 write to locked bank
      mkv(0,0,0,1, 4'b1100,4'b0011,4'b0000,0),  // 5
      mkv(0,0,0,1, 4'b1100,4'b0011,4'b0000,0),  // 6
      mkv(0,0,0,1, 4'b1100,4'b0010,4'b0001,0),  // 7  R5 bank0 precharging in cycle 8
      mkv(4,0,0,1, 4'b1100,4'b0010,4'b0001,1),  // 8  R7 precharge to locked bank
      mkv(0,0,0,1, 4'b1100,4'b0010,4'b0001,0),  // 9
      mkv(0,0,0,1, 4'b1101,4'b0010,4'b0000,0),  // 10 R5 idle in cycle 11
      mkv(3,1,1,1, 4'b1101,4'b0010,4'b0000,0),  // 11 R6 write + auto-precharge, start 16
      mkv(1,0,0,1, 4'b1100,4'b0011,4'b0000,0),  // 12 R2 reopen bank0
      mkv(0,0,0,1, 4'b1100,4'b0011,4'b0000,0),  // 13
      mkv(2,0,0,1, 4'b1100,4'b0011,4'b0000,0),  // 14 R4 plain read keeps bank open
      mkv(0,0,0,1, 4'b1100,4'b0001,4'b0010,0),  // 15 R6 bank1 precharging in cycle 16
      mkv(4,0,0,1, 4'b1100,4'b0001,4'b0010,1),  // 16 R8 premature precharge
      mkv(0,0,0,1, 4'b1100,4'b0001,4'b0010,0),  // 17
      mkv(4,0,0,1, 4'b1110,4'b0000,4'b0001,0),  // 18 R8 legal precharge; bank1 idle
      mkv(5,0,0,1, 4'b1110,4'b0000,4'b0001,1),  // 19 R10 refresh with bank busy
      mkv(0,0,0,1, 4'b1111,4'b0000,4'b0000,0),  // 20 R8 bank0 idle at 21
      mkv(0,0,0,1, 4'b1111,4'b0000,4'b0000,0),  // 21
      mkv(5,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 22 R10 refresh, idle at 31
      mkv(1,2,0,1, 4'b0000,4'b0000,4'b1111,1),  // 23 R7 activate during refresh
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 24
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 25
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 26
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 27
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 28
      mkv(0,0,0,1, 4'b0000,4'b0000,4'b1111,0),  // 29
      mkv(0,0,0,1, 4'b1111,4'b0000,4'b0000,0),  // 30 R10 all idle at 31
      mkv(1,3,0,0, 4'b1111,4'b0000,4'b0000,0),  // 31 R1 cke low: ignored
      mkv(1,3,0,1, 4'b0111,4'b1000,4'b0000,0),  // 32 R2 activate bank3
      mkv(2,2,0,1, 4'b0111,4'b1000,4'b0000,1),  // 33 R3 read to idle bank
      mkv(1,3,0,1, 4'b0111,4'b1000,4'b0000,1)   // 34 R2 activate to open bank
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input int c, input int b, input bit ap, input bit ke);
      cke  = ke;
      ba   = 2'(b);
      a10  = ap;
      cs_n = (c == 0);
      case (c)
         1:       {ras_n, cas_n, we_n} = 3'b011;
         2:       {ras_n, cas_n, we_n} = 3'b101;
         3:       {ras_n, cas_n, we_n} = 3'b100;
         4:       {ras_n, cas_n, we_n} = 3'b010;
         5:       {ras_n, cas_n, we_n} = 3'b001;
         default: {ras_n, cas_n, we_n} = 3'b111;
      endcase
      @(negedge clk);
      cs_n = 1'b1;
      {ras_n, cas_n, we_n} = 3'b111;
      cke  = 1'b1;
      a10  = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      do_reset();
      // R12 reset state
      chk("R12 idle after reset", 32'(bank_idle), 32'hF);
      chk("R12 cmd_ok after reset", 32'(cmd_ok), 32'hF);
      chk("R12 violation after reset", 32'(violation), 32'h0);
      chk("R11 all_idle after reset", 32'(all_idle), 32'h1);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] v;
         v = VEC[i];
         issue(int'(v[19:17]), int'(v[16:15]), v[14], v[13]);
         chk($sformatf("R2/R3/R5/R6/R7/R8/R10 step %0d idle", i), 32'(bank_idle), 32'(v[12:9]));
         chk($sformatf("R4/R5/R6/R13 step %0d active", i), 32'(bank_active), 32'(v[8:5]));
         chk($sformatf("R5/R6/R8/R10 step %0d prechg", i), 32'(bank_prechg), 32'(v[4:1]));
         chk($sformatf("R12 step %0d violation", i), 32'(violation), 32'(v[0]));
      end

      // R11 registered idle lag, then R5 with t_ras setting the start
      do_reset();
      burst_len = 6'd1;
      issue(1, 2, 0, 1);                        // activate bank2 in cycle c
      chk("R11 bank_idle drops", 32'(bank_idle[2]), 32'h0);
      chk("R11 all_idle lags one cycle", 32'(all_idle), 32'h1);
      issue(0, 0, 0, 1);
      chk("R11 all_idle follows", 32'(all_idle), 32'h0);
      issue(2, 2, 1, 1);                        // read+ap at c+2: start = max(c+5, c+6)
      chk("R7 cmd_ok low after auto-precharge read", 32'(cmd_ok[2]), 32'h0);
      issue(0, 0, 0, 1);
      issue(0, 0, 0, 1);                        // now cycle c+5
      chk("R5 not yet precharging before t_ras", 32'(bank_prechg[2]), 32'h0);
      chk("R5 still active before t_ras", 32'(bank_active[2]), 32'h1);
      issue(0, 0, 0, 1);                        // cycle c+6
      chk("R5 precharging at t_ras", 32'(bank_prechg[2]), 32'h1);
      issue(0, 0, 0, 1);
      issue(0, 0, 0, 1);
      chk("R5 still precharging", 32'(bank_idle[2]), 32'h0);
      issue(0, 0, 0, 1);                        // cycle c+9
      chk("R5 idle after t_rp", 32'(bank_idle[2]), 32'h1);
      chk("R7 cmd_ok back", 32'(cmd_ok[2]), 32'h1);
      burst_len = 6'd4;

      // R9 precharge all banks
      do_reset();
      issue(1, 0, 0, 1);                        // bank0 at d
      issue(1, 1, 0, 1);                        // bank1 at d+1
      repeat (4) issue(0, 0, 0, 1);             // now d+6
      issue(4, 3, 1, 1);                        // bank1 only 5 cycles open
      chk("R9 premature precharge-all flagged", 32'(violation), 32'h1);
      chk("R9 no bank changed", 32'(bank_active), 32'h3);
      issue(4, 3, 1, 1);                        // legal at d+7
      chk("R9 both banks precharging", 32'(bank_prechg), 32'h3);
      chk("R9 legal precharge-all no flag", 32'(violation), 32'h0);
      issue(0, 0, 0, 1);
      issue(0, 0, 0, 1);                        // d+10
      chk("R9 all idle after t_rp", 32'(bank_idle), 32'hF);

      // R8 precharge to an idle bank, R1 deselected command
      issue(4, 3, 0, 1);
      chk("R8 precharge idle bank no flag", 32'(violation), 32'h0);
      chk("R8 precharge idle bank no change", 32'(bank_idle), 32'hF);
      cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b011; ba = 2'd1;
      @(negedge clk);
      {ras_n, cas_n, we_n} = 3'b111;
      chk("R1 deselected activate ignored", 32'(bank_idle), 32'hF);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R12 actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule